// File: doc/BRIEF.md
# Processor Idle-State Controller

This block follows the processor's power state while the system is in its working state. It moves the core among three states. C0 is running, either at full speed or throttled. C1 is halted. C3 is deep idle, with the core clock suspended.

- C1 is entered when the bus decoder reports a halt cycle.
- C3 is entered when software reads a dedicated level register. The read returns zero.
- An NMI, an unmasked interrupt or an SMI brings the core back to C0 from either idle state.
- In C1, a bus-master request causes only a temporary excursion for the length of the transfer. When the request drops, the controller returns to C1.
- In C3, a bus-master request wakes the core only when software has enabled that with a reload bit.

A small byte-wide I/O register file holds the settings:

- the throttle enable,
- the bus-master reload enable,
- the PCI arbitration-disable level, which software sets before entering C3 and clears after waking.

A reserved C2 level register reads zero and ignores writes. A sleep-transition input forces the controller back to C0 and holds it there.

Top module: `cpu_idle_ctrl`

## Requirements
- R1: After reset, and at once when the asynchronous reset is asserted, the state output is C0 (code 00), throttle, suspend and arbitration-disable outputs are 0, and every register reads 0.
- R2: The control register at offset 00h holds the throttle enable in bit 4. Only bit 4 is writable and the other bits read 0. throttle_o is 1 exactly when that bit is 1 and the state is C0.
- R3: In C0 with no wake event, a halt cycle moves the state to C1 (code 01) after the clock edge that samples it. C1 holds until a wake event.
- R4: In C1 with a bus-master request and no wake event, the state becomes the excursion state (code 10). It stays there while the request is held and returns to C1 when the request drops. A wake event in C1 or in the excursion state moves the state to C0.
- R5: A read at offset 05h in C0 returns 0 and moves the state to C3 (code 11) after that edge. suspend_o is 1 exactly while the state is C3.
- R6: The wake events are NMI, SMI, and an interrupt while the mask input is 0. Any one of them moves C1 or C3 to C0 after the next edge. An interrupt while the mask input is 1 has no effect.
- R7: In C3, a bus-master request moves the state to C0 only when bit 1 of the register at offset 0Ch is 1. Otherwise the state stays C3. Only bit 1 of that register is writable.
- R8: Bit 0 of the register at offset 20h is writable and readable and drives arb_dis_o, whatever the state.
- R9: The reserved C2 level register at offset 04h reads 0. Writes to it have no effect, and reading it does not change the state. Any offset not named here also reads 0, and io_rdata_o is 0 when no read is strobed.
- R10: While sleep_i is 1, the state becomes C0 after the next edge and stays C0, ignoring halt cycles and level reads.
- R11: A wake event in the same cycle as a read of offset 05h keeps the state in C0.
- R12: On return to C0 from C3, throttle_o follows the throttle-enable bit as it stands at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| halt_cyc_i | input | 1 | Decoded halt bus cycle, one-cycle strobe |
| io_rd_i | input | 1 | Register read strobe |
| io_wr_i | input | 1 | Register write strobe |
| io_addr_i | input | ADDR_W | Register offset |
| io_wdata_i | input | DATA_W | Write data |
| io_rdata_o | output | DATA_W | Read data, combinational, zero without a read |
| nmi_i | input | 1 | Non-maskable interrupt |
| intr_i | input | 1 | Interrupt request |
| intr_mask_i | input | 1 | 1 masks intr_i as a wake event |
| smi_i | input | 1 | System management interrupt |
| bm_req_i | input | 1 | Bus-master request |
| sleep_i | input | 1 | Sleep-state transition in progress |
| cstate_o | output | 2 | State: 00 C0, 01 C1, 10 C1 bus-master excursion, 11 C3 |
| throttle_o | output | 1 | Throttled sub-mode of C0 active |
| suspend_o | output | 1 | Core suspend request |
| arb_dis_o | output | 1 | PCI arbitration-disable level |

## Verification
The bench sends a bus-master request in C3 with the reload bit both cleared and set. A design that ignored the bit would either wake the core early or never wake it. It holds a request across several C1 cycles and then drops it. An excursion that did not return to C1 would leave the core running. It places a wake event beside a level read in the same cycle: a wrong priority would suspend a core that has a pending event. It also writes the reserved C2 offset and reads it back, raises a masked interrupt, and applies reset in the middle of C3. A slipped register bit, a leaked mask or a state lost across reset then shows up on the outputs.

// File: rtl/cic_pkg.sv
package cic_pkg;

  typedef enum logic [1:0] {
    CS_C0    = 2'b00,
    CS_C1    = 2'b01,
    CS_C1_BM = 2'b10,
    CS_C3    = 2'b11
  } cstate_e;

  localparam int unsigned DEF_ADDR_W   = 8;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned WAKE_SRC_N   = 3;

  localparam logic [7:0] DEF_OFF_CTRL  = 8'h00;
  localparam logic [7:0] DEF_OFF_LVL2  = 8'h04;
  localparam logic [7:0] DEF_OFF_LVL3  = 8'h05;
  localparam logic [7:0] DEF_OFF_BMCTL = 8'h0C;
  localparam logic [7:0] DEF_OFF_ARB   = 8'h20;

endpackage

// File: rtl/cic_rst_sync.sv
module cic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/cic_wake.sv
module cic_wake #(
  parameter int unsigned SRC_N = cic_pkg::WAKE_SRC_N
) (
  input  logic [SRC_N-1:0] src_i,
  input  logic [SRC_N-1:0] block_i,
  output logic             wake_o
);

  logic [SRC_N-1:0] qual;

  for (genvar g = 0; g < SRC_N; g++) begin : g_qual
    assign qual[g] = src_i[g] & ~block_i[g];
  end

  assign wake_o = |qual;

endmodule

// File: rtl/cic_regs.sv
module cic_regs #(
  parameter int unsigned ADDR_W    = cic_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W    = cic_pkg::DEF_DATA_W,
  parameter logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(cic_pkg::DEF_OFF_CTRL),
  parameter logic [ADDR_W-1:0] OFF_LVL2  = ADDR_W'(cic_pkg::DEF_OFF_LVL2),
  parameter logic [ADDR_W-1:0] OFF_LVL3  = ADDR_W'(cic_pkg::DEF_OFF_LVL3),
  parameter logic [ADDR_W-1:0] OFF_BMCTL = ADDR_W'(cic_pkg::DEF_OFF_BMCTL),
  parameter logic [ADDR_W-1:0] OFF_ARB   = ADDR_W'(cic_pkg::DEF_OFF_ARB),
  parameter int unsigned THR_BIT   = 4,
  parameter int unsigned RLD_BIT   = 1,
  parameter int unsigned ARB_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              thr_en_o,
  output logic              bm_rld_o,
  output logic              arb_dis_o,
  output logic              lvl3_rd_o
);

  localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] CTRL_MASK = ONE << THR_BIT;
  localparam logic [DATA_W-1:0] BM_MASK   = ONE << RLD_BIT;
  localparam logic [DATA_W-1:0] ARB_MASK  = ONE << ARB_BIT;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] bm_q,   bm_d;
  logic [DATA_W-1:0] arb_q,  arb_d;
  logic              wr_ctrl, wr_bm, wr_arb;

  // write decode and next values
  always_comb begin
    wr_ctrl = io_wr_i && (io_addr_i == OFF_CTRL);
    wr_bm   = io_wr_i && (io_addr_i == OFF_BMCTL);
    wr_arb  = io_wr_i && (io_addr_i == OFF_ARB);
    ctrl_d  = io_wdata_i & CTRL_MASK;
    bm_d    = io_wdata_i & BM_MASK;
    arb_d   = io_wdata_i & ARB_MASK;
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bm_q <= '0;
    else if (wr_bm) bm_q <= bm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arb_q <= '0;
    else if (wr_arb) arb_q <= arb_d;
  end

  // read mux: level registers and unknown offsets return zero
  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i) begin
      if (io_addr_i == OFF_CTRL)       io_rdata_o = ctrl_q;
      else if (io_addr_i == OFF_BMCTL) io_rdata_o = bm_q;
      else if (io_addr_i == OFF_ARB)   io_rdata_o = arb_q;
      else                             io_rdata_o = '0;
    end
  end

  assign lvl3_rd_o = io_rd_i && (io_addr_i == OFF_LVL3);
  assign thr_en_o  = ctrl_q[THR_BIT];
  assign bm_rld_o  = bm_q[RLD_BIT];
  assign arb_dis_o = arb_q[ARB_BIT];

  // R8: written arbitration bit appears on the output the next cycle
  a_r8_arb_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arb |=> (arb_dis_o == $past(io_wdata_i[ARB_BIT])));

  // R9: reserved C2 level register never returns data
  a_r9_lvl2_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_i && io_addr_i == OFF_LVL2) |-> (io_rdata_o == '0));

  // R2: control readback carries nothing outside the throttle bit
  a_r2_ctrl_only_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_i && io_addr_i == OFF_CTRL) |-> ((io_rdata_o & ~CTRL_MASK) == '0));

endmodule

// File: rtl/cic_fsm.sv
module cic_fsm
  import cic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_i,
  input  logic       lvl3_rd_i,
  input  logic       wake_i,
  input  logic       bm_req_i,
  input  logic       bm_rld_i,
  input  logic       sleep_i,
  input  logic       thr_en_i,
  output logic [1:0] cstate_o,
  output logic       throttle_o,
  output logic       suspend_o
);

  cstate_e st_q, st_d;

  // next-state logic; sleep outranks wake, wake outranks entry
  always_comb begin
    st_d = st_q;
    if (sleep_i) begin
      st_d = CS_C0;
    end else begin
      case (st_q)
        CS_C0: begin
          if (wake_i)         st_d = CS_C0;
          else if (halt_i)    st_d = CS_C1;
          else if (lvl3_rd_i) st_d = CS_C3;
          else                st_d = CS_C0;
        end
        CS_C1: begin
          if (wake_i)        st_d = CS_C0;
          else if (bm_req_i) st_d = CS_C1_BM;
          else               st_d = CS_C1;
        end
        CS_C1_BM: begin
          if (wake_i)         st_d = CS_C0;
          else if (!bm_req_i) st_d = CS_C1;
          else                st_d = CS_C1_BM;
        end
        CS_C3: begin
          if (wake_i)                    st_d = CS_C0;
          else if (bm_req_i && bm_rld_i) st_d = CS_C0;
          else                           st_d = CS_C3;
        end
        default: st_d = CS_C0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CS_C0;
    else        st_q <= st_d;
  end

  assign cstate_o   = st_q;
  assign throttle_o = thr_en_i && (st_q == CS_C0);
  assign suspend_o  = (st_q == CS_C3);

  // R3: halt cycle in quiet C0 lands in C1
  a_r3_halt_enters_c1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_C0 && halt_i && !wake_i && !sleep_i) |=> (st_q == CS_C1));

  // R4: bus-master request in C1 opens an excursion
  a_r4_bm_excursion: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_C1 && bm_req_i && !wake_i && !sleep_i) |=> (st_q == CS_C1_BM));

  // R4: excursion closes back into C1 when the request drops
  a_r4_bm_return: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_C1_BM && !bm_req_i && !wake_i && !sleep_i) |=> (st_q == CS_C1));

  // R5: C3 is only reached through a level read
  a_r5_c3_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_C3 && $past(st_q) != CS_C3) |-> $past(lvl3_rd_i));

  // R6: any wake event ends an idle state
  a_r6_wake_to_c0: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != CS_C0 && wake_i) |=> (st_q == CS_C0));

  // R7: without the reload bit a bus master cannot end C3
  a_r7_bm_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_C3 && bm_req_i && !bm_rld_i && !wake_i && !sleep_i) |=> (st_q == CS_C3));

  // R10: sleep transition pins the state to C0
  a_r10_sleep_holds_c0: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> (st_q == CS_C0));

  // R11: wake beats a simultaneous level read
  a_r11_wake_beats_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_C0 && lvl3_rd_i && wake_i) |=> (st_q == CS_C0));

endmodule

// File: rtl/cpu_idle_ctrl.sv
module cpu_idle_ctrl #(
  parameter int unsigned ADDR_W   = cic_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W   = cic_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_cyc_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  input  logic              nmi_i,
  input  logic              intr_i,
  input  logic              intr_mask_i,
  input  logic              smi_i,
  input  logic              bm_req_i,
  input  logic              sleep_i,
  output logic [1:0]        cstate_o,
  output logic              throttle_o,
  output logic              suspend_o,
  output logic              arb_dis_o
);

  localparam int unsigned SRC_N = cic_pkg::WAKE_SRC_N;

  logic             rst_sync_n;
  logic             thr_en, bm_rld, lvl3_rd, wake;
  logic [SRC_N-1:0] wake_src, wake_blk;

  assign wake_src = {smi_i, intr_i,      nmi_i};
  assign wake_blk = {1'b0,  intr_mask_i, 1'b0};

  cic_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cic_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .io_rd_i    (io_rd_i),
    .io_wr_i    (io_wr_i),
    .io_addr_i  (io_addr_i),
    .io_wdata_i (io_wdata_i),
    .io_rdata_o (io_rdata_o),
    .thr_en_o   (thr_en),
    .bm_rld_o   (bm_rld),
    .arb_dis_o  (arb_dis_o),
    .lvl3_rd_o  (lvl3_rd)
  );

  cic_wake #(.SRC_N(SRC_N)) u_wake (
    .src_i   (wake_src),
    .block_i (wake_blk),
    .wake_o  (wake)
  );

  cic_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .halt_i     (halt_cyc_i),
    .lvl3_rd_i  (lvl3_rd),
    .wake_i     (wake),
    .bm_req_i   (bm_req_i),
    .bm_rld_i   (bm_rld),
    .sleep_i    (sleep_i),
    .thr_en_i   (thr_en),
    .cstate_o   (cstate_o),
    .throttle_o (throttle_o),
    .suspend_o  (suspend_o)
  );

endmodule

// File: tb/cpu_idle_ctrl_test.sv
`timescale 1ns/1ps
module cpu_idle_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       halt, rd, wr, nmi, intr, imsk, smi, bm, slp;
  logic [7:0] addr, wdata, rdata;
  logic [1:0] cst;
  logic       thr, sus, arb;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cpu_idle_ctrl uut (
    .clk(clk), .rst_n(rst_n), .halt_cyc_i(halt), .io_rd_i(rd), .io_wr_i(wr),
    .io_addr_i(addr), .io_wdata_i(wdata), .io_rdata_o(rdata), .nmi_i(nmi),
    .intr_i(intr), .intr_mask_i(imsk), .smi_i(smi), .bm_req_i(bm), .sleep_i(slp),
    .cstate_o(cst), .throttle_o(thr), .suspend_o(sus), .arb_dis_o(arb)
  );

  typedef struct packed {
    logic       h, r, w;
    logic [7:0] a, d;
    logic       n, i, m, s, b, l;
    logic [1:0] ecs;
    logic       ethr, esus, earb;
    logic [7:0] erd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 39;
  // h r w addr wdata n i m s b l | cs thr sus arb rdata req
  localparam vec_t VT [NV] = '{
    '{0,0,0,8'h00,8'h00, 0,0,0,0,0,0, 0,0,0,0,8'h00, 1},  // R1 idle
    '{0,0,1,8'h00,8'h10, 0,0,0,0,0,0, 0,1,0,0,8'h00, 2},  // R2 set throttle
    '{0,1,0,8'h00,8'h00, 0,0,0,0,0,0, 0,1,0,0,8'h10, 2},  // R2 readback
    '{0,0,1,8'h00,8'hFF, 0,0,0,0,0,0, 0,1,0,0,8'h00, 2},  // R2 all ones
    '{0,1,0,8'h00,8'h00, 0,0,0,0,0,0, 0,1,0,0,8'h10, 2},  // R2 only bit 4
    '{1,0,0,8'h00,8'h00, 0,0,0,0,0,0, 1,0,0,0,8'h00, 3},  // R3 halt
    '{0,0,0,8'h00,8'h00, 0,0,0,0,0,0, 1,0,0,0,8'h00, 3},  // R3 hold C1
    '{0,0,0,8'h00,8'h00, 0,1,1,0,0,0, 1,0,0,0,8'h00, 6},  // R6 masked irq
    '{0,0,0,8'h00,8'h00, 0,0,0,0,1,0, 2,0,0,0,8'h00, 4},  // R4 excursion
    '{0,0,0,8'h00,8'h00, 0,0,0,0,1,0, 2,0,0,0,8'h00, 4},  // R4 held
    '{0,0,0,8'h00,8'h00, 0,0,0,0,0,0, 1,0,0,0,8'h00, 4},  // R4 back to C1
    '{0,0,0,8'h00,8'h00, 1,0,0,0,0,0, 0,1,0,0,8'h00, 3},  // R3 nmi exit
    '{0,0,1,8'h20,8'h01, 0,0,0,0,0,0, 0,1,0,1,8'h00, 8},  // R8 arb set
    '{0,1,0,8'h05,8'h00, 0,0,0,0,0,0, 3,0,1,1,8'h00, 5},  // R5 enter C3
    '{0,0,0,8'h00,8'h00, 0,0,0,0,0,0, 3,0,1,1,8'h00, 5},  // R5 hold
    '{0,0,0,8'h00,8'h00, 0,0,0,0,1,0, 3,0,1,1,8'h00, 7},  // R7 bm no reload
    '{0,0,0,8'h00,8'h00, 0,0,0,1,0,0, 0,1,0,1,8'h00, 6},  // R6 smi exit
    '{0,0,1,8'h00,8'h00, 0,0,0,0,0,0, 0,0,0,1,8'h00, 2},  // R2 clear throttle
    '{0,0,1,8'h0C,8'h02, 0,0,0,0,0,0, 0,0,0,1,8'h00, 7},  // R7 set reload
    '{0,1,0,8'h0C,8'h00, 0,0,0,0,0,0, 0,0,0,1,8'h02, 7},  // R7 readback
    '{0,1,0,8'h05,8'h00, 0,0,0,0,0,0, 3,0,1,1,8'h00, 5},  // R5 enter C3
    '{0,0,0,8'h00,8'h00, 0,0,0,0,1,0, 0,0,0,1,8'h00, 7},  // R7 bm wakes
    '{0,0,1,8'h20,8'h00, 0,0,0,0,0,0, 0,0,0,0,8'h00, 8},  // R8 arb clear
    '{0,1,0,8'h05,8'h00, 0,1,0,0,0,0, 0,0,0,0,8'h00, 11}, // R11 wake + read
    '{0,0,1,8'h04,8'hFF, 0,0,0,0,0,0, 0,0,0,0,8'h00, 9},  // R9 write C2 reg
    '{0,1,0,8'h04,8'h00, 0,0,0,0,0,0, 0,0,0,0,8'h00, 9},  // R9 read C2 reg
    '{1,0,0,8'h00,8'h00, 0,0,0,0,0,0, 1,0,0,0,8'h00, 3},  // R3 halt
    '{0,0,0,8'h00,8'h00, 0,0,0,0,0,1, 0,0,0,0,8'h00, 10}, // R10 sleep
    '{1,0,0,8'h00,8'h00, 0,0,0,0,0,1, 0,0,0,0,8'h00, 10}, // R10 halt ignored
    '{0,1,0,8'h05,8'h00, 0,0,0,0,0,1, 0,0,0,0,8'h00, 10}, // R10 read ignored
    '{0,1,0,8'h05,8'h00, 0,0,0,0,0,0, 3,0,1,0,8'h00, 5},  // R5 enter C3
    '{0,0,0,8'h00,8'h00, 0,1,0,0,0,0, 0,0,0,0,8'h00, 6},  // R6 irq exit
    '{0,0,1,8'h00,8'h10, 0,0,0,0,0,0, 0,1,0,0,8'h00, 2},  // R2 throttle on
    '{0,1,0,8'h05,8'h00, 0,0,0,0,0,0, 3,0,1,0,8'h00, 5},  // R5 C3 no throttle
    '{0,0,0,8'h00,8'h00, 1,0,0,0,0,0, 0,1,0,0,8'h00, 12}, // R12 resume throttled
    '{1,0,0,8'h00,8'h00, 0,0,0,0,0,0, 1,0,0,0,8'h00, 3},  // R3 halt
    '{0,0,0,8'h00,8'h00, 0,0,0,0,1,0, 2,0,0,0,8'h00, 4},  // R4 excursion
    '{0,0,0,8'h00,8'h00, 0,0,0,1,1,0, 0,1,0,0,8'h00, 4},  // R4 wake during excursion
    '{0,0,0,8'h00,8'h00, 0,0,0,0,0,0, 0,1,0,0,8'h00, 4}   // R4 settled
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    halt = 0; rd = 0; wr = 0; addr = 8'h00; wdata = 8'h00;
    nmi = 0; intr = 0; imsk = 0; smi = 0; bm = 0; slp = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "cstate", 32'(cst), 0);
    check("R1", "throttle", 32'(thr), 0);
    check("R1", "suspend", 32'(sus), 0);
    check("R1", "arb", 32'(arb), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      string rq;
      rq = $sformatf("R%0d[v%0d]", VT[k].req, k);
      halt = VT[k].h; rd = VT[k].r; wr = VT[k].w; addr = VT[k].a; wdata = VT[k].d;
      nmi = VT[k].n; intr = VT[k].i; imsk = VT[k].m; smi = VT[k].s;
      bm = VT[k].b; slp = VT[k].l;
      #1;
      check(rq, "rdata", 32'(rdata), 32'(VT[k].erd));
      @(negedge clk);
      check(rq, "cstate", 32'(cst), 32'(VT[k].ecs));
      check(rq, "throttle", 32'(thr), 32'(VT[k].ethr));
      check(rq, "suspend", 32'(sus), 32'(VT[k].esus));
      check(rq, "arb", 32'(arb), 32'(VT[k].earb));
    end

    // R1 reset in the middle of C3 with registers set
    idle_in(); wr = 1; addr = 8'h20; wdata = 8'h01;
    @(negedge clk);
    idle_in(); rd = 1; addr = 8'h05;
    @(negedge clk);
    idle_in();
    check("R5", "cstate before reset", 32'(cst), 3);
    check("R8", "arb before reset", 32'(arb), 1);
    #2 rst_n = 1'b0;
    #1;
    check("R1", "cstate on async reset", 32'(cst), 0);
    check("R1", "suspend on async reset", 32'(sus), 0);
    check("R1", "arb on async reset", 32'(arb), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd = 1; addr = 8'h00; #1;
    check("R1", "ctrl reg after reset", 32'(rdata), 0);
    addr = 8'h20; #1;
    check("R1", "arb reg after reset", 32'(rdata), 0);
    addr = 8'h0C; #1;
    check("R1", "reload reg after reset", 32'(rdata), 0);
    rd = 0; #1;
    check("R9", "rdata without read", 32'(rdata), 0);
    addr = 8'h33; rd = 1; #1;
    check("R9", "unmapped offset", 32'(rdata), 0);
    idle_in();
    @(negedge clk);
    check("R9", "cstate after unmapped read", 32'(cst), 0);

    finish_run();
  end

endmodule